// File: doc/BRIEF.md
# Dual-Channel Timer Bus Register Frontend

This block is the bus-facing shell of a two-channel countdown timer. It sits in a 4 KB APB window and splits it into one 32-byte register bank per channel, starting at offset zero, plus a global area at the top of the window. The global area holds a test-override control, a test output register and a fixed set of identification bytes. The counting engines live outside this block. Each engine receives its reload value, control byte and load strobes from here, and returns its live count and a one-cycle expiry pulse.

The frontend keeps a raw interrupt flag for each channel, masks it with that channel's interrupt-enable bit, and drives one registered interrupt line per channel plus a combined line. When test override is on, the per-channel lines come from software-written bits instead of the timers. The combined line always follows the per-channel lines after the override.

Top module: `dtmr_apb_front`

## Requirements
- R1: Every access completes with no wait states: `pready` is always 1 and `pslverr` is always 0. Read data is captured at the end of the setup phase and is valid for the whole access phase.
- R2: Bits 11:5 of the offset select the channel bank, and only banks 0 and 1 below 0xF00 are decoded. Within a bank the offsets are: reload 0x00, live count 0x04, control 0x08, interrupt clear 0x0C, raw flag 0x10, masked flag 0x14 and background reload 0x18. Writing 0x00 or 0x18 stores the reload value, which drives `ld_value`. Both offsets read back that same stored value. A write to 0x00 pulses `ld_now` for one cycle and a write to 0x18 pulses `ld_bg` for one cycle. Reading 0x04 returns that channel's `cnt_value`.
- R3: The control register keeps bits 7:5 and 3:0, and bit 4 always reads 0. Bit 5 is the interrupt enable. After reset, control reads 0x20 and the reload value reads 0.
- R4: An expiry pulse sets the channel's raw flag. A write of any data to 0x0C clears it. If the pulse and the clear arrive in the same cycle, the flag stays set. The raw flag reads at bit 0 of offset 0x10.
- R5: The masked flag at offset 0x14, bit 0, is the raw flag ANDed with control bit 5.
- R6: With test override off, `irq_ch[i]` equals channel i's masked flag, one clock after that flag changes.
- R7: Offset 0xF00 bit 0 turns test override on and reads back, with all other bits reading 0. Offset 0xF04 is write-only and reads 0. Its bit 0 drives `irq_ch[0]` and its bit 1 drives `irq_ch[1]` while override is on.
- R8: `irq_any` is always the OR of the two `irq_ch` bits.
- R9: Offsets 0xFD0 through 0xFFC read, in ascending address order, 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Reads from undecoded offsets return 0. Writes to undecoded offsets, or to the read-only offsets 0x04, 0x10 and 0x14, change no register and no output.
- R11: Reset clears the test override enable, the test output bits and both raw flags, so both interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| prst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never an error |
| cnt_value | input | 64 | Live counts, channel 0 in bits 31:0 |
| cnt_expire | input | 2 | One-cycle expiry pulses per channel |
| ld_value | output | 64 | Stored reload values per channel |
| ld_ctrl | output | 16 | Control bytes per channel |
| ld_now | output | 2 | Immediate reload strobes |
| ld_bg | output | 2 | Background reload strobes |
| irq_ch | output | 2 | Per-channel interrupt lines |
| irq_any | output | 1 | Combined interrupt line |

## Verification
The hardest case to reach is an expiry pulse that lands in the same cycle as the write that clears the raw flag. The bench starts a clear write and raises the expiry input exactly during its access phase, so both events hit the same clock edge. A second awkward case is leaving test override while a masked flag is still pending. The bench leaves a flag set, toggles override on and off, and checks that the lines switch between the written bits and the live status. Full-window read sweeps, taken after reset and again after a sweep of writes to every undecoded or read-only offset, show that no stray write reaches any state.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int AW = 12;
  localparam int CW = 8;
  localparam logic [4:0] OFS_LOAD  = 5'h00;
  localparam logic [4:0] OFS_VALUE = 5'h04;
  localparam logic [4:0] OFS_CTRL  = 5'h08;
  localparam logic [4:0] OFS_ICLR  = 5'h0C;
  localparam logic [4:0] OFS_RIS   = 5'h10;
  localparam logic [4:0] OFS_MIS   = 5'h14;
  localparam logic [4:0] OFS_BGLD  = 5'h18;
  localparam logic [CW-1:0] CTRL_KEEP = 8'hEF;
  localparam logic [CW-1:0] CTRL_RST  = 8'h20;
  localparam int CTRL_IE = 5;
  localparam logic [AW-1:0] OFS_TCTL = 12'hF00;
  localparam logic [AW-1:0] OFS_TOUT = 12'hF04;

  function automatic logic [7:0] id_byte(input logic [3:0] k);
    case (k)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = 8'h23;
      4'd5:    id_byte = 8'hB8;
      4'd6:    id_byte = 8'h1B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/dtmr_chan_regs.sv
module dtmr_chan_regs
  import dtmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [4:0]    sub,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cnt_value,
  input  logic          expire,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] load_o,
  output logic [CW-1:0] ctrl_o,
  output logic          ld_now_o,
  output logic          ld_bg_o,
  output logic          masked_o
);
  logic [DW-1:0] load_q;
  logic [CW-1:0] ctrl_q;
  logic          raw_q;
  logic          wr_load, wr_bg, wr_ctrl, wr_clr;

  assign wr_load = wr_en && (sub == OFS_LOAD);
  assign wr_bg   = wr_en && (sub == OFS_BGLD);
  assign wr_ctrl = wr_en && (sub == OFS_CTRL);
  assign wr_clr  = wr_en && (sub == OFS_ICLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q   <= '0;
      ctrl_q   <= CTRL_RST;
      raw_q    <= 1'b0;
      ld_now_o <= 1'b0;
      ld_bg_o  <= 1'b0;
    end else begin
      ld_now_o <= wr_load;
      ld_bg_o  <= wr_bg;
      if (wr_load || wr_bg) load_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata[CW-1:0] & CTRL_KEEP;
      if (expire) raw_q <= 1'b1;
      else if (wr_clr) raw_q <= 1'b0;
    end
  end

  assign masked_o = raw_q & ctrl_q[CTRL_IE];
  assign load_o   = load_q;
  assign ctrl_o   = ctrl_q;

  always_comb begin
    case (sub)
      OFS_LOAD, OFS_BGLD: rd_val = load_q;
      OFS_VALUE:          rd_val = cnt_value;
      OFS_CTRL:           rd_val = {{(DW-CW){1'b0}}, ctrl_q};
      OFS_RIS:            rd_val = {{(DW-1){1'b0}}, raw_q};
      OFS_MIS:            rd_val = {{(DW-1){1'b0}}, masked_o};
      default:            rd_val = '0;
    endcase
  end

  // R4
  raw_set_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> raw_q);
  // R4
  raw_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && !expire) |=> !raw_q);
  // R2
  load_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_load || wr_bg) |=> (load_o == $past(wdata)));
endmodule

// File: rtl/dtmr_irq_out.sv
module dtmr_irq_out #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tctl_we,
  input  logic           tout_we,
  input  logic           tctl_d,
  input  logic [NCH-1:0] tout_d,
  input  logic [NCH-1:0] masked,
  output logic           tctl_q,
  output logic [NCH-1:0] irq_ch,
  output logic           irq_any
);
  logic [NCH-1:0] tout_q, irq_nxt;

  assign irq_nxt = tctl_q ? tout_q : masked;

  always_ff @(posedge clk) begin
    if (rst) begin
      tctl_q  <= 1'b0;
      tout_q  <= '0;
      irq_ch  <= '0;
      irq_any <= 1'b0;
    end else begin
      if (tctl_we) tctl_q <= tctl_d;
      if (tout_we) tout_q <= tout_d;
      irq_ch  <= irq_nxt;
      irq_any <= |irq_nxt;
    end
  end

  // R7
  test_follow_chk: assert property (@(posedge clk) disable iff (rst)
    tctl_q |=> (irq_ch == $past(tout_q)));
  // R6
  func_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !tctl_q |=> (irq_ch == $past(masked)));
  // R8
  any_or_chk: assert property (@(posedge clk) disable iff (rst)
    irq_any == (|irq_ch));
endmodule

// File: rtl/dtmr_apb_front.sv
module dtmr_apb_front
  import dtmr_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 32
) (
  input  logic              pclk,
  input  logic              prst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [NCH*DW-1:0] cnt_value,
  input  logic [NCH-1:0]    cnt_expire,
  output logic [NCH*DW-1:0] ld_value,
  output logic [NCH*CW-1:0] ld_ctrl,
  output logic [NCH-1:0]    ld_now,
  output logic [NCH-1:0]    ld_bg,
  output logic [NCH-1:0]    irq_ch,
  output logic              irq_any
);
  localparam int CSW = (NCH > 1) ? $clog2(NCH) : 1;

  logic          wr_acc, rd_setup, bank_hit, id_hit, tctl_q;
  logic [4:0]    sub;
  logic [CSW-1:0] csel;
  logic [DW-1:0] chan_rd [NCH];
  logic [NCH-1:0] masked;
  logic [DW-1:0] rd_mux;
  logic          unused_addr;

  assign pready      = 1'b1;
  assign pslverr     = 1'b0;
  assign unused_addr = ^paddr[1:0];

  assign wr_acc   = psel && penable && pwrite;
  assign rd_setup = psel && !penable && !pwrite;
  assign bank_hit = (paddr < OFS_TCTL) && (paddr[AW-1:5] < 7'(NCH));
  assign id_hit   = (paddr[AW-1:6] == 6'h3F) && (paddr[5:4] != 2'b00);
  assign sub      = {paddr[4:2], 2'b00};
  assign csel     = paddr[5 +: CSW];

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    dtmr_chan_regs #(.DW(DW)) u_chan (
      .clk      (pclk),
      .rst      (prst),
      .wr_en    (wr_acc && bank_hit && (csel == CSW'(i))),
      .sub      (sub),
      .wdata    (pwdata),
      .cnt_value(cnt_value[i*DW +: DW]),
      .expire   (cnt_expire[i]),
      .rd_val   (chan_rd[i]),
      .load_o   (ld_value[i*DW +: DW]),
      .ctrl_o   (ld_ctrl[i*CW +: CW]),
      .ld_now_o (ld_now[i]),
      .ld_bg_o  (ld_bg[i]),
      .masked_o (masked[i])
    );
  end

  dtmr_irq_out #(.NCH(NCH)) u_irq (
    .clk    (pclk),
    .rst    (prst),
    .tctl_we(wr_acc && (paddr[AW-1:2] == OFS_TCTL[AW-1:2])),
    .tout_we(wr_acc && (paddr[AW-1:2] == OFS_TOUT[AW-1:2])),
    .tctl_d (pwdata[0]),
    .tout_d (pwdata[NCH-1:0]),
    .masked (masked),
    .tctl_q (tctl_q),
    .irq_ch (irq_ch),
    .irq_any(irq_any)
  );

  always_comb begin
    rd_mux = '0;
    if (bank_hit)
      rd_mux = chan_rd[csel];
    else if (paddr[AW-1:2] == OFS_TCTL[AW-1:2])
      rd_mux = {{(DW-1){1'b0}}, tctl_q};
    else if (id_hit)
      rd_mux = {{(DW-8){1'b0}}, id_byte(paddr[5:2] - 4'd4)};
  end

  always_ff @(posedge pclk) begin
    if (prst) prdata <= '0;
    else if (rd_setup) prdata <= rd_mux;
  end

  // R10
  rd_unmapped_chk: assert property (@(posedge pclk) disable iff (prst)
    (rd_setup && !bank_hit && !id_hit && (paddr[AW-1:2] != OFS_TCTL[AW-1:2]))
      |=> (prdata == '0));
endmodule

// File: tb/dtmr_apb_front_tb.sv
module dtmr_apb_front_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [63:0] cnt_value = {32'h2468_ACE0, 32'h1357_9BDF};
  logic [1:0]  cnt_expire = '0;
  logic [63:0] ld_value;
  logic [15:0] ld_ctrl;
  logic [1:0]  ld_now, ld_bg, irq_ch;
  logic        irq_any;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] m_load [2];
  logic [7:0]  m_ctrl [2];
  logic        m_raw  [2];
  logic        m_itcr;

  always #2.5 clk = ~clk;

  dtmr_apb_front u_dut (
    .pclk(clk), .prst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .cnt_value(cnt_value), .cnt_expire(cnt_expire),
    .ld_value(ld_value), .ld_ctrl(ld_ctrl), .ld_now(ld_now), .ld_bg(ld_bg),
    .irq_ch(irq_ch), .irq_any(irq_any)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    chk("R1", {30'b0, pready, pslverr}, 32'd2);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_rd(input int a);
    int ch = a >> 5;
    int s  = a & 31;
    logic [7:0] idt [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h23, 8'hB8,
                             8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (a < 'hF00) begin
      if (ch >= 2) return 0;
      case (s)
        0, 24: return m_load[ch];
        4:     return cnt_value[ch*32 +: 32];
        8:     return {24'b0, m_ctrl[ch]};
        16:    return {31'b0, m_raw[ch]};
        20:    return {31'b0, m_raw[ch] & m_ctrl[ch][5]};
        default: return 0;
      endcase
    end
    if (a == 'hF00) return {31'b0, m_itcr};
    if (a >= 'hFD0) return {24'b0, idt[(a - 'hFD0) / 4]};
    return 0;
  endfunction

  function automatic string tag_of(input int a);
    if (a >= 'hFD0) return "R9";
    if (a == 'hF00) return "R7";
    if (a < 'h40 && (a & 31) != 28) return "R2";
    return "R10";
  endfunction

  function automatic bit is_writable(input int a);
    int s = a & 31;
    if (a < 'h40) return (s == 0 || s == 8 || s == 12 || s == 24);
    return (a == 'hF00 || a == 'hF04);
  endfunction

  task automatic sweep_read();
    logic [31:0] d;
    for (int a = 0; a < 4096; a += 4) begin
      apb_rd(12'(a), d);
      chk(tag_of(a), d, exp_rd(a));
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_load[i] = '0; m_ctrl[i] = 8'h20; m_raw[i] = 1'b0;
    end
    m_itcr = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    model_reset();
    idle(3);
    rst = 0;
    chk("R1", {30'b0, pready, pslverr}, 32'd2);
    chk("R11", {29'b0, irq_any, irq_ch}, 32'd0);
    sweep_read();
    apb_rd(12'h008, d); chk("R3", d, 32'h20);

    // R2 reload writes
    apb_wr(12'h000, 32'h1234_5678); m_load[0] = 32'h1234_5678;
    chk("R2", {30'b0, ld_bg, ld_now}, 32'b0001);
    chk("R2", ld_value[31:0], 32'h1234_5678);
    apb_rd(12'h018, d); chk("R2", d, 32'h1234_5678);
    apb_wr(12'h038, 32'hCAFE_F00D); m_load[1] = 32'hCAFE_F00D;
    chk("R2", {30'b0, ld_bg, ld_now}, 32'b1000);
    apb_rd(12'h020, d); chk("R2", d, 32'hCAFE_F00D);
    chk("R2", ld_value[63:32], 32'hCAFE_F00D);
    apb_rd(12'h024, d); chk("R2", d, 32'h2468_ACE0);

    // R3 control masking
    apb_wr(12'h028, 32'hFFFF_FFFF); m_ctrl[1] = 8'hEF;
    apb_rd(12'h028, d); chk("R3", d, 32'hEF);
    chk("R3", {16'b0, ld_ctrl}, 32'hEF20);
    apb_wr(12'h028, 32'h0); m_ctrl[1] = 8'h00;

    // R4/R5/R6/R8 expiry
    @(negedge clk); cnt_expire = 2'b01;
    @(negedge clk); cnt_expire = 2'b00; m_raw[0] = 1;
    @(negedge clk);
    chk("R6", {30'b0, irq_ch}, 32'b01);
    chk("R8", {31'b0, irq_any}, 32'd1);
    apb_rd(12'h010, d); chk("R4", d, 32'd1);
    apb_rd(12'h014, d); chk("R5", d, 32'd1);
    @(negedge clk); cnt_expire = 2'b10;
    @(negedge clk); cnt_expire = 2'b00; m_raw[1] = 1;
    idle(1);
    apb_rd(12'h030, d); chk("R4", d, 32'd1);
    apb_rd(12'h034, d); chk("R5", d, 32'd0);
    chk("R5", {30'b0, irq_ch}, 32'b01);

    // R4 clear, then clear colliding with expiry
    apb_wr(12'h00C, 32'h0); m_raw[0] = 0;
    idle(1);
    chk("R4", {30'b0, irq_ch}, 32'b00);
    chk("R8", {31'b0, irq_any}, 32'd0);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 12'h00C;
    @(negedge clk); penable = 1; cnt_expire = 2'b01;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; cnt_expire = 2'b00;
    m_raw[0] = 1;
    apb_rd(12'h010, d); chk("R4", d, 32'd1);
    chk("R6", {30'b0, irq_ch}, 32'b01);

    // R10 stray writes
    for (int a = 0; a < 4096; a += 4)
      if (!is_writable(a)) apb_wr(12'(a), 32'hFFFF_FFFF);
    sweep_read();
    chk("R10", {30'b0, irq_ch}, 32'b01);
    chk("R10", {16'b0, ld_ctrl}, 32'h0020);

    // R7 test override
    apb_wr(12'hF04, 32'h2);
    idle(1);
    chk("R7", {30'b0, irq_ch}, 32'b01);
    apb_rd(12'hF04, d); chk("R7", d, 32'd0);
    apb_wr(12'hF00, 32'hFFFF_FFFF); m_itcr = 1;
    apb_rd(12'hF00, d); chk("R7", d, 32'd1);
    chk("R7", {30'b0, irq_ch}, 32'b10);
    chk("R8", {31'b0, irq_any}, 32'd1);
    apb_wr(12'hF04, 32'h0); idle(1);
    chk("R7", {30'b0, irq_ch}, 32'b00);
    chk("R8", {31'b0, irq_any}, 32'd0);
    apb_wr(12'hF04, 32'h3); idle(1);
    chk("R7", {30'b0, irq_ch}, 32'b11);
    apb_wr(12'hF00, 32'h0); m_itcr = 0; idle(1);
    chk("R6", {30'b0, irq_ch}, 32'b01);

    // R11 reset clears override state and flags
    apb_wr(12'hF00, 32'h1);
    @(negedge clk); rst = 1;
    idle(2); rst = 0;
    model_reset();
    chk("R11", {29'b0, irq_any, irq_ch}, 32'd0);
    apb_rd(12'hF00, d); chk("R11", d, 32'd0);
    apb_wr(12'hF00, 32'h1); idle(1);
    chk("R11", {30'b0, irq_ch}, 32'b00);
    apb_rd(12'h010, d); chk("R11", d, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule